// File: doc/BRIEF.md
# Pre-Trigger Capture Buffer

This block is the storage half of an on-chip logic analyzer. Once a host arms it, it writes one probe word per clock into a circular memory. A separate trigger unit evaluates the match condition. When that unit reports a hit, this block marks that sample as the trigger sample. It then keeps a programmable number of earlier samples and fills the rest of the window with later ones. After that it freezes the memory and streams the window out, oldest sample first.

The host sets the trigger position, which is the number of samples to keep ahead of the trigger sample. The block latches this value when the arm command is given. For example, in a 8192-deep window a position of 4000 gives 4000 samples before the trigger sample and 4192 from the trigger sample onward. The status pins show the phase together with the pre-trigger and post-trigger fill counts.

A trigger hit that arrives before enough history has been stored is held off. It is ignored and capture keeps waiting for a later hit. The probe bus and the trigger hit are taken without any input register, and both belong to the single sampling clock.

The readout is a valid/ready stream. A beat moves on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` and `rd_data` stay unchanged. The sink may hold `rd_ready` low for any number of cycles without losing a sample.

Top module: `cap_engine`

## Requirements
- R1: After reset, status is 0 (idle), `pre_fill` and `post_fill` are 0 and `rd_valid` is low.
- R2: Status codes are 0 idle, 1 waiting for trigger, 2 post-trigger fill and 3 done. An `arm` pulse in any state moves the block to status 1 on the next cycle, clears both fill counts and aborts any readout. If `arm` and `trig_hit` are high in the same cycle, `arm` wins and the hit is ignored.
- R3: A `trig_hit` while status is 0 or 3 is ignored: status, `post_fill` and the stored window do not change.
- R4: In status 1, `pre_fill` counts the samples stored since arming and stops at the latched position. A hit in a cycle where `pre_fill` is below the position is held off, and status stays 1.
- R5: A hit in a cycle where `pre_fill` equals the position is accepted. The probe word on the bus in that same cycle becomes the trigger sample. Status becomes 2, or 3 directly when the position is DEPTH-1.
- R6: `post_fill` counts stored samples from the trigger sample onward, the trigger sample included. When it reaches DEPTH minus the position, status becomes 3, writing stops and `post_fill` holds its value.
- R7: The readout delivers exactly DEPTH words, wrapping around the memory as needed, in this order: the position samples that preceded the trigger sample, then the trigger sample, then the samples that followed it.
- R8: `rd_valid` is high only in status 3 while beats remain. A beat transfers when `rd_valid` and `rd_ready` are both high. A stalled beat keeps its data. `rd_last` marks the final beat, after which `rd_valid` stays low until the next arm.
- R9: `trig_pos` (range 0 to DEPTH-1) is sampled only in the arm cycle. Later changes to it do not affect the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_data | input | DATA_W | Probe bus, sampled every cycle while capturing |
| trig_hit | input | 1 | Trigger match from the trigger unit |
| arm | input | 1 | Start (or restart) a capture |
| trig_pos | input | AW | Samples to keep before the trigger sample |
| status | output | 2 | Phase: 0 idle, 1 waiting, 2 post-fill, 3 done |
| pre_fill | output | AW | Pre-trigger samples stored |
| post_fill | output | AW+1 | Samples stored from the trigger sample onward |
| rd_valid | output | 1 | Readout word available |
| rd_ready | input | 1 | Readout sink accepts a word |
| rd_data | output | DATA_W | Readout word, oldest first |
| rd_last | output | 1 | Final word of the window |

## Verification
Two events can land on the same clock edge.

The first pair is an arm command and a trigger hit. The bench raises both in one cycle and expects a fresh wait phase with zero fill counts. It then checks that a later capture ignores the dropped hit.

The second pair is a trigger hit and the cycle in which the pre-trigger history becomes complete. The bench pulses the hit one cycle before that point and expects it to be held off. It pulses again on the exact cycle and expects it to be accepted. The scoreboard then checks that the read-back window begins exactly position samples ahead of the stamped probe word that was present with the accepted hit.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_e;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig_hit,
  input  logic [AW-1:0] trig_pos,
  output cap_state_e    state,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] pre_cnt,
  output logic [AW:0]   post_cnt,
  output logic [AW-1:0] trig_idx,
  output logic [AW-1:0] pos_q
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE  = (AW+1)'(1);

  logic [AW-1:0] wptr;
  logic [AW:0]   post_goal;
  logic [AW:0]   post_next;
  logic          capturing;
  logic          accept;

  // samples owed from the trigger sample onward
  assign post_goal = FULL - {1'b0, pos_q};
  assign post_next = post_cnt + ONE;
  assign capturing = (state == CAP_ARMED) || (state == CAP_POST);
  // hold-off: a hit counts only once the full history is present
  assign accept    = (state == CAP_ARMED) && trig_hit && (pre_cnt == pos_q);

  assign wr_en   = capturing && !arm;
  assign wr_addr = wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= CAP_IDLE;
      wptr     <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      trig_idx <= '0;
      pos_q    <= '0;
    end else if (arm) begin
      state    <= CAP_ARMED;
      wptr     <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      pos_q    <= trig_pos;
    end else begin
      unique case (state)
        CAP_ARMED: begin
          wptr <= wptr + AW'(1);
          if (accept) begin
            trig_idx <= wptr;
            post_cnt <= ONE;
            state    <= (post_goal == ONE) ? CAP_DONE : CAP_POST;
          end else if (pre_cnt != pos_q) begin
            pre_cnt <= pre_cnt + AW'(1);
          end
        end
        CAP_POST: begin
          wptr     <= wptr + AW'(1);
          post_cnt <= post_next;
          if (post_next == post_goal) state <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // read is combinational; the array is frozen while it is read
  assign rd_data = store[rd_addr];

endmodule

// File: rtl/cap_reader.sv
module cap_reader #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          done,
  input  logic [AW-1:0] trig_idx,
  input  logic [AW-1:0] pos_q,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [AW-1:0] rd_addr
);

  localparam logic [AW:0] BEATS = (AW+1)'(DEPTH);

  logic [AW:0]   beat_cnt;
  logic [AW-1:0] oldest;

  // oldest kept sample sits pos_q slots behind the trigger index
  assign oldest   = trig_idx - pos_q;
  assign rd_addr  = oldest + beat_cnt[AW-1:0];
  assign rd_valid = done && (beat_cnt != BEATS);
  assign rd_last  = rd_valid && (beat_cnt == BEATS - (AW+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  beat_cnt <= '0;
    else if (arm)                beat_cnt <= '0;
    else if (rd_valid && rd_ready) beat_cnt <= beat_cnt + (AW+1)'(1);
  end

endmodule

// File: rtl/cap_engine.sv
module cap_engine
  import cap_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 512,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] probe_data,
  input  logic              trig_hit,
  input  logic              arm,
  input  logic [AW-1:0]     trig_pos,
  output logic [1:0]        status,
  output logic [AW-1:0]     pre_fill,
  output logic [AW:0]       post_fill,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);

  cap_state_e    state;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] trig_idx;
  logic [AW-1:0] pos_q;

  cap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .trig_hit (trig_hit),
    .trig_pos (trig_pos),
    .state    (state),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pre_cnt  (pre_fill),
    .post_cnt (post_fill),
    .trig_idx (trig_idx),
    .pos_q    (pos_q)
  );

  cap_mem #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (probe_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cap_reader #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .done     (state == CAP_DONE),
    .trig_idx (trig_idx),
    .pos_q    (pos_q),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .rd_addr  (rd_addr)
  );

  assign status = state;

endmodule

// File: rtl/cap_engine_chk.sv
module cap_engine_chk
  import cap_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          trig_hit,
  input logic [1:0]    status,
  input logic [AW-1:0] pre_fill,
  input logic [AW:0]   post_fill,
  input logic [AW-1:0] pos_q,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data
);

  logic [AW:0] goal;
  assign goal = (AW+1)'(DEPTH) - {1'b0, pos_q};

  assert_arm_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (status == CAP_ARMED) && (pre_fill == '0) && (post_fill == '0));

  assert_idle_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == CAP_IDLE) && !arm |=> (status == CAP_IDLE));

  assert_done_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == CAP_DONE) && !arm |=> (status == CAP_DONE) && $stable(post_fill));

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == CAP_ARMED) && !arm && (pre_fill != pos_q) |=> (status == CAP_ARMED));

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == CAP_ARMED) && !arm && trig_hit && (pre_fill == pos_q)
      |=> (status != CAP_ARMED) && (post_fill == (AW+1)'(1)));

  assert_post_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == CAP_POST) |-> (post_fill < goal));

  assert_valid_only_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (status == CAP_DONE));

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !arm |=> rd_valid && $stable(rd_data));

endmodule

bind cap_engine cap_engine_chk #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .trig_hit  (trig_hit),
  .status    (status),
  .pre_fill  (pre_fill),
  .post_fill (post_fill),
  .pos_q     (pos_q),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/cap_engine_tb.sv
module cap_engine_tb;

  localparam int TCLK  = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] probe_data;
  logic          trig_hit = 1'b0;
  logic          arm = 1'b0;
  logic [AW-1:0] trig_pos = '0;
  logic [1:0]    status;
  logic [AW-1:0] pre_fill;
  logic [AW:0]   post_fill;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_last;

  int n_chk = 0;
  int n_bad = 0;
  int stamp = 0;
  int ready_mode = 2;      // 0 always ready, 1 random, 2 never
  logic [7:0] lfsr = 8'hA5;
  logic [DW-1:0] exp_q[$];
  bit            stall_pend = 0;
  logic [DW-1:0] stall_data;

  always #(TCLK/2) clk = ~clk;

  cap_engine #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .probe_data(probe_data), .trig_hit(trig_hit),
    .arm(arm), .trig_pos(trig_pos), .status(status), .pre_fill(pre_fill),
    .post_fill(post_fill), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  // probe carries a running stamp so every stored word is identifiable
  assign probe_data = stamp[DW-1:0];
  always @(posedge clk) begin
    stamp <= stamp + 1;
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each transferred beat
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (stall_pend) begin
        chk(rd_valid && rd_data == stall_data, "R8", "stalled beat held",
            rd_data, stall_data);
        stall_pend = 0;
      end
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "beat beyond window", rd_data, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R7", "window word", rd_data, e);
          chk(rd_last == (exp_q.size() == 0), "R8", "last flag", rd_last,
              exp_q.size() == 0);
        end
      end else if (rd_valid && !rd_ready && !arm) begin
        stall_pend = 1;
        stall_data = rd_data;
      end
    end
  end

  // driver: arm, stimulate trigger, push the expected window
  task automatic capture(input int pos, input int early_j, input int trig_j,
                         input int mode);
    int s0;
    int n;
    ready_mode = mode;
    @(negedge clk);
    trig_pos = AW'(pos);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    trig_pos = AW'(pos + 7);   // R9: change after arm must not matter
    s0 = stamp;
    chk(status == 2'd1, "R2", "waiting after arm", status, 1);
    chk(pre_fill == 0, "R4", "pre_fill cleared", pre_fill, 0);
    for (int j = 1; ; j++) begin
      trig_hit = (j == early_j) || (j == trig_j);
      if (j == trig_j)
        chk(pre_fill == AW'(((j - 1) < pos) ? (j - 1) : pos), "R4",
            "pre_fill at hit", pre_fill, ((j - 1) < pos) ? (j - 1) : pos);
      @(negedge clk);
      trig_hit = 1'b0;
      if (j == early_j)
        chk(status == 2'd1, "R4", "early hit held off", status, 1);
      if (j == trig_j) break;
    end
    n = DEPTH - pos;
    for (int i = 0; i < DEPTH; i++)
      exp_q.push_back(DW'(s0 + trig_j - 1 - pos + i));
    chk(post_fill == 1, "R6", "post_fill after hit", post_fill, 1);
    chk(status == ((n == 1) ? 2'd3 : 2'd2), "R5", "phase after hit", status,
        (n == 1) ? 3 : 2);
    if (n > 1) repeat (n - 1) @(negedge clk);
    chk(status == 2'd3, "R6", "done at window end", status, 3);
    chk(post_fill == (AW+1)'(n), "R6", "post_fill final", post_fill, n);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, "R7", "window fully read", exp_q.size(), 0);
    @(negedge clk);
    chk(!rd_valid, "R8", "valid low after last", rd_valid, 0);
    chk(status == 2'd3, "R6", "still done after read", status, 3);
  endtask

  initial begin
    #(TCLK * 100000);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 0, "R1", "status after reset", status, 0);
    chk(pre_fill == 0 && post_fill == 0, "R1", "fills after reset",
        pre_fill + post_fill, 0);
    chk(!rd_valid, "R1", "no readout after reset", rd_valid, 0);

    // R3: hits while idle
    trig_hit = 1'b1;
    repeat (3) @(negedge clk);
    trig_hit = 1'b0;
    @(negedge clk);
    chk(status == 0, "R3", "idle ignores hit", status, 0);
    chk(post_fill == 0 && !rd_valid, "R3", "idle nothing stored",
        post_fill, 0);

    // R4/R5 boundary: hit one cycle early then exactly on time
    capture(10, 10, 11, 0);
    drain();

    // R7: memory wraps several times before the hit
    capture(10, 0, 70, 1);
    drain();

    // position zero: hit on the very first sample
    capture(0, 0, 1, 1);
    drain();

    // position DEPTH-1: done straight after the trigger sample
    capture(DEPTH - 1, 0, 40, 0);
    drain();

    // R3: hits during done leave window untouched
    capture(8, 0, 12, 2);
    trig_hit = 1'b1;
    repeat (3) @(negedge clk);
    trig_hit = 1'b0;
    @(negedge clk);
    chk(status == 2'd3, "R3", "done ignores hit", status, 3);
    chk(post_fill == (AW+1)'(DEPTH - 8), "R3", "post_fill unchanged",
        post_fill, DEPTH - 8);
    ready_mode = 1;
    drain();

    // R2: abort mid-readout with arm and hit in one cycle
    capture(4, 0, 10, 2);
    ready_mode = 0;
    repeat (5) @(negedge clk);
    ready_mode = 2;
    repeat (2) @(negedge clk);
    exp_q.delete();
    trig_pos = AW'(3);
    arm = 1'b1;
    trig_hit = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    trig_hit = 1'b0;
    chk(status == 2'd1, "R2", "arm beats hit", status, 1);
    chk(pre_fill == 0 && post_fill == 0, "R2", "fills cleared on rearm",
        pre_fill + post_fill, 0);
    chk(!rd_valid, "R2", "readout aborted", rd_valid, 0);
    @(negedge clk);
    chk(status == 2'd1 && post_fill == 0, "R2", "dropped hit not taken",
        status, 1);

    capture(5, 3, 20, 1);
    drain();

    summary();
  end

endmodule